// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block keeps a word-addressed data store that several requesters share, together with a small reservation table that has one entry per requester. A load-linked request returns the addressed word one cycle later and records a reservation on the enclosing line for that requester. A store-conditional writes its data only when the requester still holds a reservation on the same line. It reports the outcome on a status bit. A plain store always writes.

A reservation is tracked per line rather than per word. It can disappear without any conflicting write. The events that remove it are a load-linked to the same line by a rival requester, a pulse announcing eviction of that line, or a context-switch pulse for the owning requester. Software must therefore retry a failed store-conditional.

Requests arrive on a single port tagged with a requester id. Eviction and context-switch pulses may arrive in the same cycle as a request. Those clears take effect before the request is evaluated.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no requester holds a reservation, every stored word reads as zero and `rsp_valid` is low.
- R2: A load-linked (op code 0) produces `rsp_valid` one cycle later, with `rsp_rdata` equal to the addressed word and `rsp_sc_ok` low. It also records a reservation on that line for the requester.
- R3: A store-conditional (op code 1) whose requester holds a reservation on the addressed line writes the data, and one cycle later reports `rsp_valid` with `rsp_sc_ok` high and `rsp_rdata` zero. Any word of the reserved line qualifies.
- R4: A store-conditional without a matching reservation leaves the store unchanged and reports `rsp_sc_ok` low.
- R5: A store-conditional removes the requester's own reservation, whether it succeeds or fails.
- R6: Each requester holds at most one reservation. A new load-linked by the same requester replaces the old line.
- R7: A load-linked by one requester removes every other requester's reservation on the same line.
- R8: A completed write, whether a plain store or a successful store-conditional, removes every reservation on the written line. Reservations on other lines are untouched.
- R9: An eviction pulse removes every reservation on the named line. If it coincides with a store-conditional to that line, that store-conditional fails.
- R10: `ctx_switch[i]` removes only requester i's reservation. A load-linked by requester i in the same cycle still leaves it reserved.
- R11: A plain store (op code 2) writes unconditionally and produces no response.
- R12: The line number is the word address with its low log2(LINE_WORDS) bits dropped. With 4-word lines, addresses 128 to 131 share a line, and 127 belongs to the line before it.
- R13: Op code 3 does nothing: no write, no response, no change to any reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_id | input | 2 | Requester issuing the request |
| req_op | input | 2 | 0 load-linked, 1 store-conditional, 2 plain store, 3 no operation |
| req_addr | input | 8 | Word address |
| req_wdata | input | 32 | Store data |
| evict_valid | input | 1 | Eviction pulse for one line |
| evict_line | input | 6 | Line being evicted |
| ctx_switch | input | 4 | One context-switch pulse per requester |
| rsp_valid | output | 1 | Response to the previous cycle's load-linked or store-conditional |
| rsp_rdata | output | 32 | Word returned by load-linked, zero otherwise |
| rsp_sc_ok | output | 1 | Store-conditional succeeded |

## Verification
The bench builds the block with four requesters, 8-bit word addresses and 4-word lines. Four requesters make room for two rivals on one line while a third requester holds an unrelated line as a bystander. The 4-word line makes it possible to test a store-conditional to a different word of the reserved line. It also brings the boundary between lines 31 and 32 (addresses 127 and 128) within reach. The small address space keeps the zeroed reset image cheap, and a bench model can mirror the whole store.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [1:0] {
        OP_LL  = 2'd0,
        OP_SC  = 2'd1,
        OP_ST  = 2'd2,
        OP_NOP = 2'd3
    } llsc_op_e;

endpackage

// File: rtl/llsc_word_store.sv
module llsc_word_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // storage array: cleared on reset, one write port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/llsc_resv_slot.sv
module llsc_resv_slot #(
    parameter int LINE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drop_pre,   // eviction or context switch, applied first
    input  logic              set_own,    // own load-linked
    input  logic              clr_own,    // own store-conditional
    input  logic              kill_line,  // rival load-linked or completed write
    input  logic [LINE_W-1:0] req_line,
    output logic              vld,
    output logic              pre_vld,
    output logic [LINE_W-1:0] tag
);
    typedef struct packed {
        logic              vld;
        logic [LINE_W-1:0] tag;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d  = slot_q;
        pre_vld = slot_q.vld & ~drop_pre;
        if (set_own) begin
            slot_d.vld = 1'b1;
            slot_d.tag = req_line;
        end else if (clr_own) begin
            slot_d.vld = 1'b0;
        end else if (kill_line && (slot_q.tag == req_line)) begin
            slot_d.vld = 1'b0;
        end else begin
            slot_d.vld = pre_vld;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign vld = slot_q.vld;
    assign tag = slot_q.tag;

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int NUM_REQ    = 4,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4,
    localparam int ID_W      = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1,
    localparam int OFS_W     = (LINE_WORDS > 1) ? $clog2(LINE_WORDS) : 0,
    localparam int LINE_W    = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ID_W-1:0]   req_id,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              evict_valid,
    input  logic [LINE_W-1:0] evict_line,
    input  logic [NUM_REQ-1:0] ctx_switch,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_sc_ok
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] rdata;
        logic              ok;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    llsc_op_e          op;
    logic [LINE_W-1:0] req_line;
    logic              is_ll, is_sc, is_st;
    logic              sc_ok, wr_en;
    logic [DATA_W-1:0] mem_rdata;

    logic [NUM_REQ-1:0] resv_vld_q;
    logic [NUM_REQ-1:0] resv_pre;
    logic [LINE_W-1:0]  resv_tag [NUM_REQ];

    assign op       = llsc_op_e'(req_op);
    assign req_line = req_addr[ADDR_W-1:OFS_W];
    assign is_ll    = req_valid && (op == OP_LL);
    assign is_sc    = req_valid && (op == OP_SC);
    assign is_st    = req_valid && (op == OP_ST);

    // store-conditional hit uses the reservation after same-cycle clears
    assign sc_ok = is_sc && resv_pre[req_id] && (resv_tag[req_id] == req_line);
    assign wr_en = is_st || sc_ok;

    llsc_word_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (req_addr),
        .wr_data (req_wdata),
        .rd_addr (req_addr),
        .rd_data (mem_rdata)
    );

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_slot
        logic own, drop, kill;
        assign own  = (req_id == ID_W'(g));
        assign drop = ctx_switch[g] || (evict_valid && (evict_line == resv_tag[g]));
        assign kill = wr_en || (is_ll && !own);

        llsc_resv_slot #(
            .LINE_W (LINE_W)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .drop_pre  (drop),
            .set_own   (is_ll && own),
            .clr_own   (is_sc && own),
            .kill_line (kill),
            .req_line  (req_line),
            .vld       (resv_vld_q[g]),
            .pre_vld   (resv_pre[g]),
            .tag       (resv_tag[g])
        );
    end

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = is_ll || is_sc;
        rsp_d.rdata = is_ll ? mem_rdata : '0;
        rsp_d.ok    = sc_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_rdata = rsp_q.rdata;
    assign rsp_sc_ok = rsp_q.ok;

endmodule

// File: rtl/llsc_monitor_checks.sv
module llsc_monitor_checks #(
    parameter int NUM_REQ = 4,
    parameter int ID_W    = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [ID_W-1:0]    req_id,
    input logic [1:0]         req_op,
    input logic [NUM_REQ-1:0] ctx_switch,
    input logic               rsp_valid,
    input logic               rsp_sc_ok,
    input logic [NUM_REQ-1:0] resv_vld
);
    // R2: a response only follows a load-linked or store-conditional
    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && (req_op == 2'd0 || req_op == 2'd1)));

    // R3: success is only ever reported for a store-conditional
    p_ok_only_sc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_sc_ok |-> (rsp_valid && $past(req_op == 2'd1)));

    // R5: store-conditional leaves its requester unreserved
    p_sc_drops_own_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd1) |=> !resv_vld[$past(req_id)]);

    // R6: load-linked leaves its requester reserved
    p_ll_sets_own_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd0) |=> resv_vld[$past(req_id)]);

    // R13: op code 3 is silent
    p_nop_silent_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd3) |=> !rsp_valid);

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_ctx
        // R10: context switch clears the owner unless it load-links now
        p_ctx_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (ctx_switch[g] && !(req_valid && req_op == 2'd0 && req_id == ID_W'(g)))
            |=> !resv_vld[g]);
    end

endmodule

bind llsc_monitor llsc_monitor_checks #(
    .NUM_REQ (NUM_REQ),
    .ID_W    (ID_W)
) u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_id     (req_id),
    .req_op     (req_op),
    .ctx_switch (ctx_switch),
    .rsp_valid  (rsp_valid),
    .rsp_sc_ok  (rsp_sc_ok),
    .resv_vld   (resv_vld_q)
);

// File: tb/llsc_monitor_bench.sv
module llsc_monitor_bench;
    localparam int NUM_REQ    = 4;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 32;
    localparam int LINE_WORDS = 4;
    localparam int ID_W       = 2;
    localparam int OFS_W      = 2;
    localparam int LINE_W     = ADDR_W - OFS_W;
    localparam int DEPTH      = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ID_W-1:0]   req_id = '0;
    logic [1:0]        req_op = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              evict_valid = 1'b0;
    logic [LINE_W-1:0] evict_line = '0;
    logic [NUM_REQ-1:0] ctx_switch = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;
    logic              rsp_sc_ok;

    always #5 clk = ~clk;

    llsc_monitor #(
        .NUM_REQ    (NUM_REQ),
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .LINE_WORDS (LINE_WORDS)
    ) u_llsc_monitor (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_id (req_id),
        .req_op (req_op), .req_addr (req_addr), .req_wdata (req_wdata),
        .evict_valid (evict_valid), .evict_line (evict_line),
        .ctx_switch (ctx_switch), .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata), .rsp_sc_ok (rsp_sc_ok)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [DATA_W-1:0] ref_mem [DEPTH];
    bit                ref_vld [NUM_REQ];
    int                ref_line [NUM_REQ];

    logic [DATA_W-1:0] exp_data [$];
    bit                exp_ok [$];
    string             exp_tag [$];

    task automatic check(bit cond, string tag, string what, longint act, longint exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_write(int addr, logic [DATA_W-1:0] data);
        ref_mem[addr] = data;
        for (int i = 0; i < NUM_REQ; i++)
            if (ref_vld[i] && ref_line[i] == (addr >> OFS_W)) ref_vld[i] = 1'b0;
    endtask

    // op 0..3 drive a request; op 4 drives no request, only pulses
    task automatic do_op(int id, int op, int addr, logic [DATA_W-1:0] data,
                         bit ev, int ev_line, logic [NUM_REQ-1:0] ctx, string tag);
        int  line;
        bit  ok;
        @(negedge clk);
        req_valid   = (op < 4);
        req_id      = ID_W'(id);
        req_op      = 2'(op);
        req_addr    = ADDR_W'(addr);
        req_wdata   = data;
        evict_valid = ev;
        evict_line  = LINE_W'(ev_line);
        ctx_switch  = ctx;
        line = addr >> OFS_W;
        for (int i = 0; i < NUM_REQ; i++)
            if (ctx[i] || (ev && ref_line[i] == ev_line)) ref_vld[i] = 1'b0;
        case (op)
            0: begin
                exp_data.push_back(ref_mem[addr]);
                exp_ok.push_back(1'b0);
                exp_tag.push_back(tag);
                for (int i = 0; i < NUM_REQ; i++)
                    if (i != id && ref_vld[i] && ref_line[i] == line) ref_vld[i] = 1'b0;
                ref_vld[id]  = 1'b1;
                ref_line[id] = line;
            end
            1: begin
                ok = ref_vld[id] && ref_line[id] == line;
                ref_vld[id] = 1'b0;
                if (ok) model_write(addr, data);
                exp_data.push_back('0);
                exp_ok.push_back(ok);
                exp_tag.push_back(tag);
            end
            2: model_write(addr, data);
            default: ;
        endcase
    endtask

    // monitor: pops expected responses away from the active edge
    always @(negedge clk) begin
        #1;
        if (rst_n && rsp_valid) begin
            if (exp_data.size() == 0) begin
                check(1'b0, "R2/R11/R13", "unexpected response", 1, 0);
            end else begin
                logic [DATA_W-1:0] ed;
                bit                eo;
                string             et;
                ed = exp_data.pop_front();
                eo = exp_ok.pop_front();
                et = exp_tag.pop_front();
                check(rsp_rdata == ed, et, "rdata", rsp_rdata, ed);
                check(rsp_sc_ok == eo, et, "sc_ok", rsp_sc_ok, eo);
            end
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        for (int i = 0; i < NUM_REQ; i++) begin ref_vld[i] = 1'b0; ref_line[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);

        do_op(1, 1,   9, 32'h11,   0, 0, 4'b0, "R4");   // no reservation after reset
        do_op(1, 0,   9, 0,        0, 0, 4'b0, "R4");   // store did not happen
        do_op(0, 0,   5, 0,        0, 0, 4'b0, "R1");   // zero image
        do_op(0, 1,   6, 32'h66,   0, 0, 4'b0, "R3");   // other word, same line
        do_op(2, 0,   6, 0,        0, 0, 4'b0, "R3");
        do_op(0, 1,   5, 32'h1,    0, 0, 4'b0, "R5");   // cleared by own success
        do_op(3, 0,  40, 0,        0, 0, 4'b0, "R2");
        do_op(3, 1,  80, 32'h2,    0, 0, 4'b0, "R4");   // wrong line
        do_op(3, 1,  40, 32'h3,    0, 0, 4'b0, "R5");   // cleared by own failure
        do_op(0, 0,  12, 0,        0, 0, 4'b0, "R6");
        do_op(0, 0,  16, 0,        0, 0, 4'b0, "R6");
        do_op(0, 1,  12, 32'h4,    0, 0, 4'b0, "R6");   // replaced line
        do_op(1, 0,  32, 0,        0, 0, 4'b0, "R7");
        do_op(2, 0,  33, 0,        0, 0, 4'b0, "R7");
        do_op(1, 1,  32, 32'h5,    0, 0, 4'b0, "R7");   // rival took the line
        do_op(2, 1,  34, 32'h6,    0, 0, 4'b0, "R7");
        do_op(0, 0,  48, 0,        0, 0, 4'b0, "R8");
        do_op(3, 0, 100, 0,        0, 0, 4'b0, "R8");
        do_op(1, 2,  49, 32'h7,    0, 0, 4'b0, "R8");
        do_op(0, 1,  48, 32'h8,    0, 0, 4'b0, "R8");   // killed by plain store
        do_op(3, 1, 100, 32'h9,    0, 0, 4'b0, "R8");   // other line survives
        do_op(1, 0,  49, 0,        0, 0, 4'b0, "R8");
        do_op(2, 0,  64, 0,        0, 0, 4'b0, "R9");
        do_op(2, 1,  64, 32'hA,    1, 16, 4'b0, "R9");  // same-cycle eviction
        do_op(2, 0,  68, 0,        0, 0, 4'b0, "R9");
        do_op(0, 4,   0, 0,        1, 16, 4'b0, "R9");  // eviction of a different line
        do_op(2, 1,  68, 32'hB,    0, 0, 4'b0, "R9");
        do_op(1, 0,  72, 0,        0, 0, 4'b0, "R10");
        do_op(3, 0,  90, 0,        0, 0, 4'b0, "R10");
        do_op(0, 4,   0, 0,        0, 0, 4'b0010, "R10");
        do_op(1, 1,  72, 32'hC,    0, 0, 4'b0, "R10");
        do_op(3, 1,  90, 32'hD,    0, 0, 4'b0, "R10");
        do_op(0, 0, 120, 0,        0, 0, 4'b0001, "R10");
        do_op(0, 1, 120, 32'hE,    0, 0, 4'b0, "R10");
        do_op(2, 2, 200, 32'hBEEF, 0, 0, 4'b0, "R11");
        do_op(2, 0, 200, 0,        0, 0, 4'b0, "R11");
        do_op(3, 0, 131, 0,        0, 0, 4'b0, "R12");
        do_op(3, 1, 128, 32'hF0,   0, 0, 4'b0, "R12");  // 128 and 131 share a line
        do_op(3, 0, 127, 0,        0, 0, 4'b0, "R12");
        do_op(3, 1, 128, 32'hF1,   0, 0, 4'b0, "R12");  // 127 is on the line before
        do_op(3, 0, 128, 0,        0, 0, 4'b0, "R12");
        do_op(1, 0, 204, 0,        0, 0, 4'b0, "R13");
        do_op(0, 3, 200, 32'h1,    0, 0, 4'b0, "R13");
        do_op(1, 1, 204, 32'h77,   0, 0, 4'b0, "R13");  // reservation untouched
        do_op(0, 0, 200, 0,        0, 0, 4'b0, "R13");
        do_op(0, 4,   0, 0,        0, 0, 4'b0, "idle");
        repeat (3) @(negedge clk);
        check(exp_data.size() == 0, "R2", "responses outstanding", exp_data.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule